// File: doc/BRIEF.md
# Address/Data Register Memory Unit

This block is the memory side of a simple stored-program machine. A processor never addresses the storage cells directly. It first places an address in the address register and, for a write, a word in the data register. It then raises a start strobe with the operation select set to fetch or store. A one-hot line decoder turns the held address into a single cell select. A small sequencer then moves one word between the data register and the selected cell. When the transfer is complete it raises a one-cycle completion pulse.

Every access takes the same fixed time, whatever the address. The sequencer has three states. `ST_IDLE` waits for start. `ST_DECODE` registers the one-hot select from the address register. `ST_XFER` moves the word: a fetch copies the cell into the data register, and a store writes the data register into the cell. The transitions are: `ST_IDLE`→`ST_DECODE` when start is seen, `ST_DECODE`→`ST_XFER` always, and `ST_XFER`→`ST_IDLE` always. The completion pulse is registered off `ST_XFER`. With the defaults, the array holds 256 words of 12 bits. Its contents are established by earlier stores and not by reset.

Top module: `mem_xfer_unit`

## Requirements
- R1: An active-low reset clears the address register and the data register to zero, so `mdr_out` reads 0. Reset leaves the cell array untouched, so a word stored before reset is fetched intact afterwards.
- R2: In idle, `mar_load` captures the low ADDR_W bits of `bus_in` into the address register at the next rising edge. In idle, `mdr_load` captures all of `bus_in` into the data register, and the value shows on `mdr_out` after that edge.
- R3: The decoder drives exactly one of its 2^ADDR_W select lines, the one whose index equals the address register. Every address therefore reaches its own cell, including addresses 0 and 2^ADDR_W-1.
- R4: A fetch (`op_store`=0 at start) copies the selected cell into the data register. The cell keeps its contents, so it reads the same on a second fetch.
- R5: A store (`op_store`=1 at start) writes the data register into the selected cell and replaces every bit of the old word. The data register and all other cells are unchanged.
- R6: `done` is high for exactly one cycle. That cycle follows the second rising edge after the edge that accepts start, and the result is on `mdr_out` in the same cycle. The latency is the same for every address and both operations.
- R7: `start` is ignored while an access is in progress, so holding it through an access produces only one completion pulse.
- R8: `mar_load` and `mdr_load` are ignored while an access is in progress.
- R9: The operation is taken from `op_store` at the edge that accepts start. Changing `op_store` later in the access has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | DATA_W (12) | Processor bus word for the address and data registers |
| mar_load | input | 1 | Load the address register from `bus_in` |
| mdr_load | input | 1 | Load the data register from `bus_in` |
| op_store | input | 1 | Operation select: 0 fetch, 1 store |
| start | input | 1 | Begin an access |
| done | output | 1 | One-cycle completion pulse |
| mdr_out | output | DATA_W (12) | Data register contents |

## Verification
On every cycle, the assertions check the following: the sequencer's fixed state order, the single-cycle completion pulse, and that the registered select is one-hot and points at the held address. They also check that the address register is frozen while busy and that the data register holds through a store. Only the bench scenarios can show that words actually land in and return from the right cells. This covers both ends of the address range, full replacement on overwrite, non-destructive reads, survival of the array across reset, and the exact cycle in which `done` and the fetched word appear.

// File: rtl/mxu_pkg.sv
package mxu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_XFER   = 2'd2
    } mxu_state_e;

    typedef enum logic {
        OP_FETCH = 1'b0,
        OP_STORE = 1'b1
    } mxu_op_e;

endpackage

// File: rtl/mxu_addr_decoder.sv
module mxu_addr_decoder #(
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned LINES = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [LINES-1:0]  line
);

    // one comparator per select line; only the matching index goes high
    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign line[g] = (addr == ADDR_W'(g));
    end

endmodule

// File: rtl/mxu_cell_array.sv
module mxu_cell_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 12,
    localparam int unsigned LINES = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [LINES-1:0]  sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cells  [LINES];
    logic [DATA_W-1:0] masked [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_cell
        // each cell is written only when its own line is selected
        always_ff @(posedge clk) begin
            if (wr_en && sel[g]) begin
                cells[g] <= wr_data;
            end
        end
        assign masked[g] = cells[g] & {DATA_W{sel[g]}};
    end

    // one-hot select: an OR over the masked words is the read multiplexer
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < int'(LINES); i++) begin
            rd_data = rd_data | masked[i];
        end
    end

endmodule

// File: rtl/mxu_sequencer.sv
module mxu_sequencer
    import mxu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       op_store,
    output mxu_state_e state,
    output logic       busy,
    output logic       dec_en,
    output logic       rd_xfer,
    output logic       wr_xfer,
    output logic       done
);

    mxu_state_e state_q, state_d;
    mxu_op_e    op_q;
    logic       done_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_DECODE;
            ST_DECODE: state_d = ST_XFER;
            ST_XFER:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // operation latched only on the accepting edge (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_FETCH;
        end else if (state_q == ST_IDLE && start) begin
            op_q <= mxu_op_e'(op_store);
        end
    end

    // completion pulse, registered off the transfer state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_XFER);
        end
    end

    // outputs
    always_comb begin
        busy    = 1'b1;
        dec_en  = 1'b0;
        rd_xfer = 1'b0;
        wr_xfer = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy    = 1'b0;
            ST_DECODE: dec_en  = 1'b1;
            ST_XFER: begin
                rd_xfer = (op_q == OP_FETCH);
                wr_xfer = (op_q == OP_STORE);
            end
            default:   busy    = 1'b0;
        endcase
    end

    assign state = state_q;
    assign done  = done_q;

    p_decode_then_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE) |=> (state_q == ST_XFER));
    p_xfer_then_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |=> (state_q == ST_IDLE));
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_after_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |=> done_q);
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_DECODE));
    p_op_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE) |=> $stable(op_q));

endmodule

// File: rtl/mem_xfer_unit.sv
module mem_xfer_unit
    import mxu_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 12,
    localparam int unsigned LINES = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              mar_load,
    input  logic              mdr_load,
    input  logic              op_store,
    input  logic              start,
    output logic              done,
    output logic [DATA_W-1:0] mdr_out
);

    mxu_state_e        state;
    logic              busy, dec_en, rd_xfer, wr_xfer;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mdr_q;
    logic [LINES-1:0]  line_d, sel_q;
    logic [DATA_W-1:0] rd_data;

    mxu_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_store (op_store),
        .state    (state),
        .busy     (busy),
        .dec_en   (dec_en),
        .rd_xfer  (rd_xfer),
        .wr_xfer  (wr_xfer),
        .done     (done)
    );

    mxu_addr_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .addr (mar_q),
        .line (line_d)
    );

    mxu_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .sel     (sel_q),
        .wr_en   (wr_xfer),
        .wr_data (mdr_q),
        .rd_data (rd_data)
    );

    // address register: bus loads only while idle (R2, R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (mar_load && !busy) begin
            mar_q <= bus_in[ADDR_W-1:0];
        end
    end

    // data register: fetch transfer or idle bus load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdr_q <= '0;
        end else if (rd_xfer) begin
            mdr_q <= rd_data;
        end else if (mdr_load && !busy) begin
            mdr_q <= bus_in;
        end
    end

    // registered one-hot select, captured in the decode state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (dec_en) begin
            sel_q <= line_d;
        end
    end

    assign mdr_out = mdr_q;

    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_xfer || wr_xfer) |-> ($countones(sel_q) == 1));
    p_sel_matches_mar_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_xfer || wr_xfer) |-> sel_q[mar_q]);
    p_mar_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mar_q));
    p_mdr_kept_on_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_xfer |=> $stable(mdr_q));
    p_mdr_frozen_decode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |=> $stable(mdr_q));

endmodule

// File: tb/mem_xfer_unit_tb.sv
`timescale 1ns/1ps
module mem_xfer_unit_tb_top;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 12;
    localparam int          NVEC   = 13;

    // vector: {op(1: store), addr(8), data(12), expected mdr_out(12)}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 12'hA5C, 12'hA5C},
        {1'b1, 8'hFF, 12'h3E1, 12'h3E1},
        {1'b1, 8'h80, 12'hFFF, 12'hFFF},
        {1'b1, 8'h01, 12'h7A2, 12'h7A2},
        {1'b0, 8'h00, 12'h000, 12'hA5C},
        {1'b0, 8'hFF, 12'h000, 12'h3E1},
        {1'b0, 8'h80, 12'h000, 12'hFFF},
        {1'b1, 8'h01, 12'h05A, 12'h05A},
        {1'b0, 8'h01, 12'h000, 12'h05A},
        {1'b0, 8'h80, 12'h000, 12'hFFF},
        {1'b1, 8'h7F, 12'h123, 12'h123},
        {1'b0, 8'h7F, 12'h000, 12'h123},
        {1'b0, 8'h00, 12'h000, 12'hA5C}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] bus_in = '0;
    logic              mar_load = 1'b0, mdr_load = 1'b0, op_store = 1'b0, start = 1'b0;
    logic              done;
    logic [DATA_W-1:0] mdr_out;
    int                checks = 0;
    int                errors = 0;

    always #2.5 clk = ~clk;

    mem_xfer_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk (clk), .rst_n (rst_n), .bus_in (bus_in), .mar_load (mar_load),
        .mdr_load (mdr_load), .op_store (op_store), .start (start),
        .done (done), .mdr_out (mdr_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_mar(input logic [ADDR_W-1:0] a);
        @(negedge clk); mar_load = 1'b1; bus_in = DATA_W'(a);
        @(negedge clk); mar_load = 1'b0;
    endtask

    task automatic load_mdr(input logic [DATA_W-1:0] d);
        @(negedge clk); mdr_load = 1'b1; bus_in = d;
        @(negedge clk); mdr_load = 1'b0;
        chk("R2 mdr load", 32'(mdr_out), 32'(d));
    endtask

    // start accepted at the next edge; done expected only after the third edge (R6)
    task automatic access(input logic op);
        @(negedge clk); start = 1'b1; op_store = op;
        @(negedge clk); start = 1'b0;
        chk("R6 done low decode", 32'(done), 0);
        @(negedge clk);
        chk("R6 done low xfer", 32'(done), 0);
        @(negedge clk);
        chk("R6 done pulse", 32'(done), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset mdr", 32'(mdr_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle done", 32'(done), 0);

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            load_mar(VEC[i][31:24]);
            if (VEC[i][32]) load_mdr(VEC[i][23:12]);
            access(VEC[i][32]);
            chk(VEC[i][32] ? "R5 store mdr" : "R4 fetch R3 cell", 32'(mdr_out), 32'(VEC[i][11:0]));
            @(negedge clk);
            chk("R6 done one cycle", 32'(done), 0);
        end

        // R7: start held through an access gives a single pulse
        load_mar(8'hFF);
        @(negedge clk); start = 1'b1; op_store = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); start = 1'b0;
        chk("R7 first done", 32'(done), 1);
        chk("R7 fetched", 32'(mdr_out), 32'h3E1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 no second done", 32'(done), 0);
        end

        // R8: bus loads during an access are dropped
        load_mar(8'h80);
        @(negedge clk); start = 1'b1; op_store = 1'b0;
        @(negedge clk); start = 1'b0; mar_load = 1'b1; mdr_load = 1'b1; bus_in = 12'h0FF;
        @(negedge clk); mar_load = 1'b0; mdr_load = 1'b0;
        @(negedge clk);
        chk("R8 mdr not loaded", 32'(mdr_out), 32'hFFF);
        @(negedge clk);
        access(1'b0);
        chk("R8 mar not loaded", 32'(mdr_out), 32'hFFF);

        // R9: op change mid-access has no effect
        load_mar(8'h7F);
        load_mdr(12'h999);
        @(negedge clk); start = 1'b1; op_store = 1'b0;
        @(negedge clk); start = 1'b0; op_store = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 still fetch", 32'(mdr_out), 32'h123);
        op_store = 1'b0;
        load_mdr(12'h000);
        access(1'b0);
        chk("R9 cell not written", 32'(mdr_out), 32'h123);

        // R1: reset clears registers but keeps array
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mdr cleared", 32'(mdr_out), 0);
        @(negedge clk); rst_n = 1'b1;
        access(1'b0);
        chk("R1 mar zero and array kept", 32'(mdr_out), 32'hA5C);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule